// File: doc/BRIEF.md
# SD Command Line Engine

This block is the host side of the single-bit command channel of an SD card. It takes a 6-bit command index and a 32-bit argument and sends them as one 48-bit frame, most significant bit first. The block appends the 7-bit checksum and the framing bits itself. After the stop bit it releases the line and ignores two turnaround clocks. It then waits for the card's start bit, shifts in a 48-bit or 136-bit reply, and checks the checksum of short replies. Some commands expect no reply, and the caller selects that case as well.

The engine does not generate the card clock. A clock divider elsewhere supplies two one-cycle strobes in the system clock domain. `drv_en` marks the falling card-clock edge, where the host changes its output. `smp_en` marks the rising edge, where the host samples the line. The pad driver uses the line value, the drive enable and the sampled input as three separate signals. A command is handed over with a valid/ready handshake. Completion is a one-cycle `done` pulse with error flags. A programmable limit bounds how long the engine waits for a reply.

Top module: `sd_cmd_engine`

## Requirements
- R1: An accepted command goes out as 48 bits, most significant first: a 0, then a 1, then the 6-bit index, the 32-bit argument, a 7-bit checksum and a closing 1. `cmd_oe` is high for exactly those 48 bit periods, and `cmd_out` and `cmd_oe` change only in cycles where `drv_en` is high.
- R2: The checksum uses the polynomial x^7 + x^3 + 1 with a zero seed, computed over the first 40 frame bits. Index 55 with a zero argument must produce 0x770000000065.
- R3: Once the stop bit has been driven, the next drive strobe drops `cmd_oe`. Whenever `cmd_oe` is low, `cmd_out` is 1.
- R4: The first two sample strobes after release are turnaround. A 0 seen on `cmd_in` during them does not start a reply.
- R5: After turnaround, the first sampled 0 starts the reply. `rsp_kind` selects the reply length: 00 means none, 01 means 48 bits, and 1x means 136 bits. At `done`, `rsp_bits` holds the received bits, start bit included, right-aligned with the upper bits cleared.
- R6: For a 48-bit reply, `crc_err` is raised when the checksum of bits 47..8 differs from bits 7..1. The reply 0x370000012083 must pass this check.
- R7: With `crc_skip` set, a 48-bit reply never raises `crc_err`. A 136-bit reply never raises it either.
- R8: If `wait_limit` consecutive post-turnaround samples all read 1, the wait ends with `timeout_err` set and no reply bits captured. A limit of 0 means 2^TO_W samples.
- R9: `cmd_ready` is high only while the engine is idle. `done` lasts one cycle, and `crc_err` and `timeout_err` are valid with it and never both set. A command with no reply finishes right after release with both flags clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| drv_en | input | 1 | Falling card-clock strobe (host drive point) |
| smp_en | input | 1 | Rising card-clock strobe (host sample point) |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Engine idle, accepts a command |
| cmd_index | input | 6 | Command index |
| cmd_arg | input | 32 | Command argument |
| rsp_kind | input | 2 | Reply kind: 00 none, 01 short, 1x long |
| crc_skip | input | 1 | Do not check a short reply's checksum |
| wait_limit | input | TO_W | Reply wait limit in sample strobes |
| done | output | 1 | One-cycle completion pulse |
| crc_err | output | 1 | Reply checksum mismatch |
| timeout_err | output | 1 | No reply start within the limit |
| rsp_bits | output | 136 | Captured reply, right-aligned |
| cmd_out | output | 1 | Line value to drive |
| cmd_oe | output | 1 | Line drive enable |
| cmd_in | input | 1 | Line value from the pad |

## Verification
The assertions check several properties on every cycle. The line reads high whenever it is not driven, and `cmd_out` and `cmd_oe` move only on drive strobes. The handshake and the single-cycle `done` are checked the same way, along with the rule that the two error flags are exclusive and that the reply counter stays in range. The bench scenarios cover what only whole transactions can show. These are the exact frame bits and checksums for known commands, and the rejection of a corrupted reply. They also cover the skip flag, long replies, and a 0 during turnaround that must be ignored. The timeout is tested on both sides of its limit, and the bench confirms that no second frame starts while the engine is busy.

// File: rtl/sd_cmd_pkg.sv
package sd_cmd_pkg;

  localparam int FRAME_BITS = 48;
  localparam int LONG_BITS  = 136;
  localparam int HDR_BITS   = 40;
  localparam int CNT_W      = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEND,
    ST_TURN,
    ST_WAIT,
    ST_RECV,
    ST_FIN,
    ST_DONE
  } eng_state_e;

  // One serial step of the 7-bit checksum, polynomial x^7 + x^3 + 1.
  function automatic logic [6:0] crc7_next(input logic [6:0] crc, input logic din);
    logic fb;
    fb = din ^ crc[6];
    return {crc[5:0], 1'b0} ^ (fb ? 7'h09 : 7'h00);
  endfunction

endpackage

// File: rtl/sd_cmd_crc7.sv
module sd_cmd_crc7 #(
  parameter int N = 40
) (
  input  logic [N-1:0] bits,
  output logic [6:0]   crc
);
  logic [6:0] stage [0:N];

  assign stage[0] = 7'h00;

  for (genvar i = 0; i < N; i++) begin : g_step
    assign stage[i+1] = sd_cmd_pkg::crc7_next(stage[i], bits[N-1-i]);
  end

  assign crc = stage[N];
endmodule

// File: rtl/sd_cmd_tx.sv
module sd_cmd_tx (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load,
  input  logic        shift,
  input  logic [5:0]  index,
  input  logic [31:0] arg,
  output logic        tx_bit
);
  import sd_cmd_pkg::*;

  logic [HDR_BITS-1:0]   hdr;
  logic [6:0]            crc;
  logic [FRAME_BITS-1:0] sr_q, sr_d;

  assign hdr = {1'b0, 1'b1, index, arg};

  sd_cmd_crc7 #(.N(HDR_BITS)) crc_i (
    .bits (hdr),
    .crc  (crc)
  );

  always_comb begin
    sr_d = sr_q;
    if (load) begin
      sr_d = {hdr, crc, 1'b1};
    end else if (shift) begin
      sr_d = {sr_q[FRAME_BITS-2:0], 1'b1};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q <= '1;
    end else if (load || shift) begin
      sr_q <= sr_d;
    end
  end

  assign tx_bit = sr_q[FRAME_BITS-1];
endmodule

// File: rtl/sd_cmd_rx.sv
module sd_cmd_rx (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clear,
  input  logic                 shift,
  input  logic                 din,
  output logic [sd_cmd_pkg::LONG_BITS-1:0] rsp,
  output logic                 short_crc_ok
);
  import sd_cmd_pkg::*;

  logic [LONG_BITS-1:0] sr_q, sr_d;
  logic [6:0]           calc;

  always_comb begin
    sr_d = sr_q;
    if (clear) begin
      sr_d = '0;
    end else if (shift) begin
      sr_d = {sr_q[LONG_BITS-2:0], din};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q <= '0;
    end else if (clear || shift) begin
      sr_q <= sr_d;
    end
  end

  sd_cmd_crc7 #(.N(HDR_BITS)) crc_i (
    .bits (sr_q[FRAME_BITS-1:8]),
    .crc  (calc)
  );

  assign short_crc_ok = (calc == sr_q[7:1]);
  assign rsp          = sr_q;
endmodule

// File: rtl/sd_cmd_engine.sv
module sd_cmd_engine #(
  parameter int TO_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            drv_en,
  input  logic            smp_en,
  input  logic            cmd_valid,
  output logic            cmd_ready,
  input  logic [5:0]      cmd_index,
  input  logic [31:0]     cmd_arg,
  input  logic [1:0]      rsp_kind,
  input  logic            crc_skip,
  input  logic [TO_W-1:0] wait_limit,
  output logic            done,
  output logic            crc_err,
  output logic            timeout_err,
  output logic [135:0]    rsp_bits,
  output logic            cmd_out,
  output logic            cmd_oe,
  input  logic            cmd_in
);
  import sd_cmd_pkg::*;

  localparam logic [CNT_W-1:0] FRAME_CNT = CNT_W'(FRAME_BITS);
  localparam logic [CNT_W-1:0] LONG_CNT  = CNT_W'(LONG_BITS);

  // Reset: asserted asynchronously, released through two flops.
  logic rst_s1_q, rst_ns;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_ns   <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_ns   <= rst_s1_q;
    end
  end

  eng_state_e       state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [TO_W-1:0]  wait_q, wait_d;
  logic [TO_W-1:0]  limit_q, limit_d, limit_m1;
  logic             turn_q, turn_d;
  logic [1:0]       kind_q, kind_d;
  logic             skip_q, skip_d;
  logic             out_q, out_d, oe_q, oe_d;
  logic             cerr_q, cerr_d, terr_q, terr_d;
  logic             tx_load, tx_shift, tx_bit;
  logic             rx_clear, rx_shift, rx_crc_ok;
  logic [CNT_W-1:0] rsp_len;
  logic [LONG_BITS-1:0] rx_rsp;

  sd_cmd_tx tx_i (
    .clk    (clk),
    .rst_n  (rst_ns),
    .load   (tx_load),
    .shift  (tx_shift),
    .index  (cmd_index),
    .arg    (cmd_arg),
    .tx_bit (tx_bit)
  );

  sd_cmd_rx rx_i (
    .clk          (clk),
    .rst_n        (rst_ns),
    .clear        (rx_clear),
    .shift        (rx_shift),
    .din          (cmd_in),
    .rsp          (rx_rsp),
    .short_crc_ok (rx_crc_ok)
  );

  assign rsp_len  = kind_q[1] ? LONG_CNT : FRAME_CNT;
  assign limit_m1 = limit_q - {{(TO_W-1){1'b0}}, 1'b1};

  always_comb begin
    state_d  = state_q;
    cnt_d    = cnt_q;
    wait_d   = wait_q;
    limit_d  = limit_q;
    turn_d   = turn_q;
    kind_d   = kind_q;
    skip_d   = skip_q;
    out_d    = out_q;
    oe_d     = oe_q;
    cerr_d   = cerr_q;
    terr_d   = terr_q;
    tx_load  = 1'b0;
    tx_shift = 1'b0;
    rx_clear = 1'b0;
    rx_shift = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (cmd_valid) begin
          tx_load  = 1'b1;
          rx_clear = 1'b1;
          kind_d   = rsp_kind;
          skip_d   = crc_skip;
          limit_d  = wait_limit;
          cerr_d   = 1'b0;
          terr_d   = 1'b0;
          cnt_d    = '0;
          state_d  = ST_SEND;
        end
      end
      ST_SEND: begin
        if (drv_en) begin
          if (cnt_q == FRAME_CNT) begin
            oe_d   = 1'b0;
            out_d  = 1'b1;
            turn_d = 1'b0;
            state_d = (kind_q == 2'b00) ? ST_DONE : ST_TURN;
          end else begin
            oe_d     = 1'b1;
            out_d    = tx_bit;
            tx_shift = 1'b1;
            cnt_d    = cnt_q + 1'b1;
          end
        end
      end
      ST_TURN: begin
        if (smp_en) begin
          if (turn_q) begin
            wait_d  = '0;
            state_d = ST_WAIT;
          end else begin
            turn_d = 1'b1;
          end
        end
      end
      ST_WAIT: begin
        if (smp_en) begin
          if (!cmd_in) begin
            rx_shift = 1'b1;
            cnt_d    = CNT_W'(1);
            state_d  = ST_RECV;
          end else if (wait_q == limit_m1) begin
            terr_d  = 1'b1;
            state_d = ST_DONE;
          end else begin
            wait_d = wait_q + 1'b1;
          end
        end
      end
      ST_RECV: begin
        if (smp_en) begin
          rx_shift = 1'b1;
          cnt_d    = cnt_q + 1'b1;
          if (cnt_q + 1'b1 == rsp_len) begin
            state_d = ST_FIN;
          end
        end
      end
      ST_FIN: begin
        cerr_d  = (kind_q == 2'b01) && !skip_q && !rx_crc_ok;
        state_d = ST_DONE;
      end
      ST_DONE: begin
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      wait_q  <= '0;
      limit_q <= '0;
      turn_q  <= 1'b0;
      kind_q  <= 2'b00;
      skip_q  <= 1'b0;
      out_q   <= 1'b1;
      oe_q    <= 1'b0;
      cerr_q  <= 1'b0;
      terr_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      wait_q  <= wait_d;
      limit_q <= limit_d;
      turn_q  <= turn_d;
      kind_q  <= kind_d;
      skip_q  <= skip_d;
      out_q   <= out_d;
      oe_q    <= oe_d;
      cerr_q  <= cerr_d;
      terr_q  <= terr_d;
    end
  end

  assign cmd_ready   = (state_q == ST_IDLE);
  assign done        = (state_q == ST_DONE);
  assign crc_err     = cerr_q;
  assign timeout_err = terr_q;
  assign rsp_bits    = rx_rsp;
  assign cmd_out     = out_q;
  assign cmd_oe      = oe_q;

  // R3
  idle_high_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    !cmd_oe |-> cmd_out);

  // R1
  drive_edge_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    !drv_en |=> ($stable(cmd_out) && $stable(cmd_oe)));

  // R9
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    (cmd_valid && cmd_ready) |=> !cmd_ready);

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    done |=> !done);

  // R9
  flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    done |-> !(crc_err && timeout_err));

  // R1
  oe_busy_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    cmd_oe |-> !cmd_ready);

  // R5
  rx_len_chk: assert property (@(posedge clk) disable iff (!rst_ns)
    cnt_q <= LONG_CNT);
endmodule

// File: tb/sd_cmd_engine_tb.sv
module sd_cmd_engine_tb_top;

  localparam int TO_W = 16;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            drv_en = 1'b0;
  logic            smp_en = 1'b0;
  logic            cmd_valid = 1'b0;
  logic            cmd_ready;
  logic [5:0]      cmd_index = '0;
  logic [31:0]     cmd_arg = '0;
  logic [1:0]      rsp_kind = '0;
  logic            crc_skip = 1'b0;
  logic [TO_W-1:0] wait_limit = '0;
  logic            done, crc_err, timeout_err;
  logic [135:0]    rsp_bits;
  logic            cmd_out, cmd_oe;
  logic            cmd_in = 1'b1;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [47:0]  exp_frames[$];
  string        frame_tags[$];
  logic [137:0] exp_res[$];
  string        res_tags[$];

  sd_cmd_engine #(.TO_W(TO_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .drv_en(drv_en), .smp_en(smp_en),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_index(cmd_index),
    .cmd_arg(cmd_arg), .rsp_kind(rsp_kind), .crc_skip(crc_skip),
    .wait_limit(wait_limit), .done(done), .crc_err(crc_err),
    .timeout_err(timeout_err), .rsp_bits(rsp_bits), .cmd_out(cmd_out),
    .cmd_oe(cmd_oe), .cmd_in(cmd_in)
  );

  always #10 clk = ~clk;

  // Strobes: change shortly after each falling edge; monitors read them at the
  // falling edge, so the values seen are those used at the preceding rising edge.
  initial begin
    int phase = 0;
    forever begin
      @(negedge clk);
      #2;
      phase = (phase + 1) % 4;
      drv_en = (phase == 0);
      smp_en = (phase == 2);
    end
  end

  task automatic check(input bit ok, input string tag, input logic [137:0] act, input logic [137:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [47:0] make_frame(input logic [5:0] idx, input logic [31:0] arg);
    logic [39:0] h;
    logic [6:0]  c;
    h = {2'b01, idx, arg};
    c = 7'h00;
    for (int i = 39; i >= 0; i--) begin
      logic fb;
      fb = h[i] ^ c[6];
      c = {c[5:0], 1'b0};
      if (fb) c = c ^ 7'h09;
    end
    return {h, c, 1'b1};
  endfunction

  // Frame monitor (R1, R2, R3)
  initial begin
    logic [47:0] frm = '0;
    int n = 0;
    forever begin
      @(negedge clk);
      if (smp_en) begin
        if (cmd_oe) begin
          frm = {frm[46:0], cmd_out};
          n++;
        end else if (n > 0) begin
          check(n == 48, "R1 frame length", 138'(n), 138'd48);
          if (exp_frames.size() == 0) begin
            check(0, "R9 unexpected frame", 138'(frm), 138'd0);
          end else begin
            logic [47:0] e;
            string t;
            e = exp_frames.pop_front();
            t = frame_tags.pop_front();
            check(frm == e, t, 138'(frm), 138'(e));
          end
          n = 0;
        end
      end
    end
  end

  // Result monitor (R5..R9)
  initial begin
    forever begin
      @(negedge clk);
      if (done) begin
        logic [137:0] act;
        act = {rsp_bits, crc_err, timeout_err};
        if (exp_res.size() == 0) begin
          check(0, "R9 unexpected done", act, 138'd0);
        end else begin
          logic [137:0] e;
          string t;
          e = exp_res.pop_front();
          t = res_tags.pop_front();
          check(act == e, t, act, e);
        end
      end
    end
  end

  task automatic send_cmd(input logic [5:0] idx, input logic [31:0] arg,
                          input logic [1:0] kind, input bit skip, input int lim);
    @(negedge clk);
    cmd_valid  = 1'b1;
    cmd_index  = idx;
    cmd_arg    = arg;
    rsp_kind   = kind;
    crc_skip   = skip;
    wait_limit = TO_W'(lim);
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic card_reply(input logic [135:0] bits, input int len, input int delay, input bit glitch);
    int s;
    @(negedge clk);
    while (!cmd_oe) @(negedge clk);
    while (cmd_oe) @(negedge clk);
    if (glitch) cmd_in = 1'b0;
    s = 0;
    while (s < 2) begin
      if (smp_en) s++;
      if (s < 2) @(negedge clk);
    end
    cmd_in = 1'b1;
    s = 0;
    while (s < delay) begin
      @(negedge clk);
      if (smp_en) s++;
    end
    for (int i = len - 1; i >= 0; i--) begin
      @(negedge clk);
      while (!drv_en) @(negedge clk);
      cmd_in = bits[i];
    end
    @(negedge clk);
    while (!drv_en) @(negedge clk);
    cmd_in = 1'b1;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (!cmd_ready) @(negedge clk);
    repeat (6) @(negedge clk);
  endtask

  localparam logic [135:0] LONG_RSP = 136'h3F_1D414453_44202020_10A0400B_C10088FF;

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    // Reset state (R9, R3)
    check(cmd_ready == 1'b1, "R9 reset ready", 138'(cmd_ready), 138'd1);
    check(cmd_oe == 1'b0, "R3 reset oe", 138'(cmd_oe), 138'd0);
    check(cmd_out == 1'b1, "R3 reset out", 138'(cmd_out), 138'd1);
    check(done == 1'b0, "R9 reset done", 138'(done), 138'd0);

    // S1: CMD55, no reply; checks the known frame and busy ready (R2, R9)
    exp_frames.push_back(48'h770000000065); frame_tags.push_back("R2 cmd55 frame");
    exp_res.push_back('0); res_tags.push_back("R9 no-reply result");
    fork
      send_cmd(6'd55, 32'h0, 2'b00, 1'b0, 8);
      begin
        repeat (40) @(negedge clk);
        check(cmd_ready == 1'b0, "R9 busy ready", 138'(cmd_ready), 138'd0);
      end
    join
    wait_idle();

    // S2: other known frames (R1, R2)
    exp_frames.push_back(48'h400000000095); frame_tags.push_back("R2 cmd0 frame");
    exp_res.push_back('0); res_tags.push_back("R9 cmd0 result");
    send_cmd(6'd0, 32'h0, 2'b00, 1'b0, 8);
    wait_idle();
    exp_frames.push_back(48'h69001000005F); frame_tags.push_back("R2 acmd41 frame");
    exp_res.push_back('0); res_tags.push_back("R9 acmd41 result");
    send_cmd(6'd41, 32'h00100000, 2'b00, 1'b0, 8);
    wait_idle();

    // S3: short reply passing its checksum (R5, R6)
    exp_frames.push_back(make_frame(6'd55, 32'h0)); frame_tags.push_back("R1 cmd55 frame");
    exp_res.push_back({136'h370000012083, 2'b00}); res_tags.push_back("R6 good short reply");
    fork
      send_cmd(6'd55, 32'h0, 2'b01, 1'b0, 20);
      card_reply(136'h370000012083, 48, 4, 1'b0);
    join
    wait_idle();

    // S4: corrupted checksum (R6)
    exp_frames.push_back(make_frame(6'd3, 32'h00010000)); frame_tags.push_back("R1 cmd3 frame");
    exp_res.push_back({136'h370000012085, 2'b10}); res_tags.push_back("R6 bad short reply");
    fork
      send_cmd(6'd3, 32'h00010000, 2'b01, 1'b0, 20);
      card_reply(136'h370000012085, 48, 0, 1'b0);
    join
    wait_idle();

    // S5: all-ones checksum field with skip (R7)
    exp_frames.push_back(make_frame(6'd41, 32'h00100000)); frame_tags.push_back("R1 acmd41 frame");
    exp_res.push_back({136'h3F00FF8000FF, 2'b00}); res_tags.push_back("R7 skipped check");
    fork
      send_cmd(6'd41, 32'h00100000, 2'b01, 1'b1, 20);
      card_reply(136'h3F00FF8000FF, 48, 2, 1'b0);
    join
    wait_idle();

    // S6: long reply (R5, R7)
    exp_frames.push_back(make_frame(6'd2, 32'h0)); frame_tags.push_back("R1 cmd2 frame");
    exp_res.push_back({LONG_RSP, 2'b00}); res_tags.push_back("R5 long reply");
    fork
      send_cmd(6'd2, 32'h0, 2'b10, 1'b0, 20);
      card_reply(LONG_RSP, 136, 1, 1'b0);
    join
    wait_idle();

    // S7: zero during turnaround ignored (R4)
    exp_frames.push_back(make_frame(6'd3, 32'h0)); frame_tags.push_back("R1 cmd3b frame");
    exp_res.push_back({136'h03B368050019, 2'b00}); res_tags.push_back("R4 turnaround glitch");
    fork
      send_cmd(6'd3, 32'h0, 2'b01, 1'b0, 20);
      card_reply(136'h03B368050019, 48, 3, 1'b1);
    join
    wait_idle();

    // S8: no card at all (R8)
    exp_frames.push_back(make_frame(6'd8, 32'h000001AA)); frame_tags.push_back("R1 cmd8 frame");
    exp_res.push_back({136'h0, 2'b01}); res_tags.push_back("R8 silent timeout");
    send_cmd(6'd8, 32'h000001AA, 2'b01, 1'b0, 5);
    wait_idle();

    // S9: start on the last allowed sample (R8 boundary)
    exp_frames.push_back(make_frame(6'd55, 32'h0)); frame_tags.push_back("R1 cmd55c frame");
    exp_res.push_back({136'h370000012083, 2'b00}); res_tags.push_back("R8 limit-1 ok");
    fork
      send_cmd(6'd55, 32'h0, 2'b01, 1'b0, 6);
      card_reply(136'h370000012083, 48, 5, 1'b0);
    join
    wait_idle();

    // S10: start one sample too late (R8 boundary)
    exp_frames.push_back(make_frame(6'd55, 32'h0)); frame_tags.push_back("R1 cmd55d frame");
    exp_res.push_back({136'h0, 2'b01}); res_tags.push_back("R8 limit late");
    fork
      send_cmd(6'd55, 32'h0, 2'b01, 1'b0, 6);
      card_reply(136'h370000012083, 48, 6, 1'b0);
    join
    wait_idle();

    check(exp_frames.size() == 0, "R1 frames outstanding", 138'(exp_frames.size()), 138'd0);
    check(exp_res.size() == 0, "R9 results outstanding", 138'(exp_res.size()), 138'd0);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule